// File: doc/BRIEF.md
# Three-Master Four-Slave Crossbar Switch with Per-Slave Round-Robin

This block joins three bus masters to four slave ports. Each master raises a request with a 32-bit address, a write flag and 64-bit write data, and holds all of them until it sees its ready. The two top address bits pick the slave. Masters that aim at different slaves are served at the same time, each through its own path.

Each slave port has an arbiter of its own. When several masters want the same slave, the arbiter grants one of them and keeps that grant until the slave acknowledges. The other masters see no ready and wait. The arbiter starts its search at the master after the one it granted last, so no master can lock out the others.

A transaction is one address phase and one data phase. The grant is registered, so the slave sees its request one cycle after the master raises it. The slave's ready, read data and error bit go back in the same cycle, and only to the master that owns the port.

Top module: `mport_switch`

## Requirements
- R1: A master's target slave is its address bits [31:30]: the value 0, 1, 2 or 3 selects slave port 0, 1, 2 or 3. While a slave port's request is high, its address bits [31:30] equal the port number.
- R2: Masters that target different slaves in the same cycle are all granted on the same clock edge, and their transactions run at the same time.
- R3: A slave port has at most one owner at a time, and a master owns at most one port. A master that is not granted sees its ready held low until it is granted and its own transaction completes.
- R4: Among the masters contending for a port, the winner is the first one found when counting upward, modulo 3, from the master the port granted last. After reset every port counts as having last granted master 2, so master 0 wins the first contention.
- R5: A grant holds while the slave's ready is low, and it is released on the edge where the slave's ready is high. The next grant is decided in the cycle after the release, so back-to-back transactions on one port with a slave latency of L cycles finish L+2 cycles apart.
- R6: A slave's ready, read data and error bit reach only the master that owns the port. Every other master's ready stays low, and a master receives exactly one ready pulse per request.
- R7: The owner's address, write flag and write data appear on the slave port for the whole time the port is owned.
- R8: During and right after reset no slave port requests and no master sees ready. A reset in the middle of a transaction drops the grant and returns every port's last-granted record to master 2.
- R9: When a master requests an idle slave port, the port's request rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 3 | Per-master transaction request, held until that master's ready |
| m_we | input | 3 | Per-master write flag |
| m_addr | input | 96 | Per-master address, master m in bits [32m+31:32m] |
| m_wdata | input | 192 | Per-master write data, master m in bits [64m+63:64m] |
| m_rdata | output | 192 | Per-master read data returned from the owned slave |
| m_ready | output | 3 | Per-master completion strobe |
| m_err | output | 3 | Per-master error bit passed back from the owned slave |
| s_req | output | 4 | Per-slave request, high while the port is owned |
| s_we | output | 4 | Per-slave write flag of the owner |
| s_addr | output | 128 | Per-slave address of the owner, slave s in bits [32s+31:32s] |
| s_wdata | output | 256 | Per-slave write data of the owner |
| s_rdata | input | 256 | Per-slave read data |
| s_ready | input | 4 | Per-slave acknowledge that ends the transaction |
| s_err | input | 4 | Per-slave error bit for the current transaction |

## Verification
Suppose a request is driven in cycle N and the slave answers L cycles after it sees its request. The winner's ready is then due in cycle N+1+L, and the k-th master served at a contended port sees its ready in cycle N+1+L+k(L+2). The read data and the error bit are due in that same cycle. The bench works out each master's due cycle from its own model of the round-robin order. It samples on the falling edge, records the cycle in which each ready is seen, and counts every ready pulse. A ready that arrives early, arrives late or arrives twice therefore fails a check. Write traffic is checked as a per-port sum of accepted write data once every master in a vector has finished.

// File: rtl/mpsw_pkg.sv
package mpsw_pkg;

  localparam int unsigned DEF_MASTERS = 3;
  localparam int unsigned DEF_SLAVES  = 4;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_DATA_W  = 64;

  typedef enum logic {
    PORT_FREE = 1'b0,
    PORT_HELD = 1'b1
  } port_state_e;

  // width of an index that can name n items (at least one bit)
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mpsw_decode.sv
module mpsw_decode
  import mpsw_pkg::*;
#(
  parameter int unsigned NUM_M  = DEF_MASTERS,
  parameter int unsigned NUM_S  = DEF_SLAVES,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic [NUM_M-1:0]        m_req,
  input  logic [NUM_M*ADDR_W-1:0] m_addr,
  output logic [NUM_S*NUM_M-1:0]  want_mat
);

  localparam int unsigned SIW = idx_w(NUM_S);

  // slave index sits in the top address bits
  function automatic logic [SIW-1:0] target_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SIW];
  endfunction

  // want_mat bit s*NUM_M+m: master m requests slave s
  for (genvar s = 0; s < NUM_S; s++) begin : g_slv
    for (genvar m = 0; m < NUM_M; m++) begin : g_mst
      assign want_mat[s*NUM_M+m] =
        m_req[m] && (target_of(m_addr[m*ADDR_W +: ADDR_W]) == SIW'(s));
    end
  end

endmodule

// File: rtl/mpsw_port_arb.sv
module mpsw_port_arb
  import mpsw_pkg::*;
#(
  parameter int unsigned NUM_M  = DEF_MASTERS,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_M-1:0]        want,
  input  logic [NUM_M-1:0]        m_we,
  input  logic [NUM_M*ADDR_W-1:0] m_addr,
  input  logic [NUM_M*DATA_W-1:0] m_wdata,
  input  logic                    s_ready,
  output logic                    s_req,
  output logic                    s_we,
  output logic [ADDR_W-1:0]       s_addr,
  output logic [DATA_W-1:0]       s_wdata,
  output logic [NUM_M-1:0]        own,
  output logic                    grant_evt,
  output logic                    release_evt
);

  localparam int unsigned MIW = idx_w(NUM_M);
  localparam logic [MIW-1:0] RST_LAST = MIW'(NUM_M - 1);

  // Returns {found, index}: first requester after 'last', wrapping.
  function automatic logic [MIW:0] rr_pick(input logic [MIW-1:0] last,
                                           input logic [NUM_M-1:0] req);
    logic [MIW:0] r;
    int cand;
    r = '0;
    for (int k = NUM_M; k >= 1; k--) begin
      cand = int'(last) + k;
      if (cand >= int'(NUM_M)) cand = cand - int'(NUM_M);
      if (req[cand]) r = {1'b1, MIW'(cand)};
    end
    return r;
  endfunction

  port_state_e     st;
  logic [MIW-1:0]  owner;
  logic [MIW-1:0]  last_gnt;
  logic [MIW:0]    pick;

  assign pick        = rr_pick(last_gnt, want);
  assign grant_evt   = (st == PORT_FREE) && pick[MIW];
  assign release_evt = (st == PORT_HELD) && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PORT_FREE;
      owner    <= '0;
      last_gnt <= RST_LAST;
    end else if (grant_evt) begin
      st       <= PORT_HELD;
      owner    <= pick[MIW-1:0];
      last_gnt <= pick[MIW-1:0];
    end else if (release_evt) begin
      st       <= PORT_FREE;
    end
  end

  assign s_req = (st == PORT_HELD);

  for (genvar m = 0; m < NUM_M; m++) begin : g_own
    assign own[m] = s_req && (owner == MIW'(m));
  end

  // forward the owner's request fields
  always_comb begin
    s_we    = 1'b0;
    s_addr  = '0;
    s_wdata = '0;
    for (int m = 0; m < int'(NUM_M); m++) begin
      if (own[m]) begin
        s_we    = m_we[m];
        s_addr  = m_addr[m*ADDR_W +: ADDR_W];
        s_wdata = m_wdata[m*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/mpsw_resp_route.sv
module mpsw_resp_route
  import mpsw_pkg::*;
#(
  parameter int unsigned NUM_M  = DEF_MASTERS,
  parameter int unsigned NUM_S  = DEF_SLAVES,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic [NUM_S*NUM_M-1:0]  own_mat,
  input  logic [NUM_S*DATA_W-1:0] s_rdata,
  input  logic [NUM_S-1:0]        s_ready,
  input  logic [NUM_S-1:0]        s_err,
  output logic [NUM_M*DATA_W-1:0] m_rdata,
  output logic [NUM_M-1:0]        m_ready,
  output logic [NUM_M-1:0]        m_err
);

  for (genvar m = 0; m < NUM_M; m++) begin : g_mst
    always_comb begin
      m_ready[m]                   = 1'b0;
      m_err[m]                     = 1'b0;
      m_rdata[m*DATA_W +: DATA_W]  = '0;
      for (int s = 0; s < int'(NUM_S); s++) begin
        if (own_mat[s*NUM_M+m]) begin
          m_ready[m]                  = s_ready[s];
          m_err[m]                    = s_err[s];
          m_rdata[m*DATA_W +: DATA_W] = s_rdata[s*DATA_W +: DATA_W];
        end
      end
    end
  end

endmodule

// File: rtl/mport_switch.sv
module mport_switch
  import mpsw_pkg::*;
#(
  parameter int unsigned NUM_M  = DEF_MASTERS,
  parameter int unsigned NUM_S  = DEF_SLAVES,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_M-1:0]        m_req,
  input  logic [NUM_M-1:0]        m_we,
  input  logic [NUM_M*ADDR_W-1:0] m_addr,
  input  logic [NUM_M*DATA_W-1:0] m_wdata,
  output logic [NUM_M*DATA_W-1:0] m_rdata,
  output logic [NUM_M-1:0]        m_ready,
  output logic [NUM_M-1:0]        m_err,
  output logic [NUM_S-1:0]        s_req,
  output logic [NUM_S-1:0]        s_we,
  output logic [NUM_S*ADDR_W-1:0] s_addr,
  output logic [NUM_S*DATA_W-1:0] s_wdata,
  input  logic [NUM_S*DATA_W-1:0] s_rdata,
  input  logic [NUM_S-1:0]        s_ready,
  input  logic [NUM_S-1:0]        s_err
);

  // named internal events, observed by the bound checker
  logic [NUM_S*NUM_M-1:0] want_mat;
  logic [NUM_S*NUM_M-1:0] own_mat;
  logic [NUM_S-1:0]       grant_evt;
  logic [NUM_S-1:0]       release_evt;

  mpsw_decode #(
    .NUM_M (NUM_M),
    .NUM_S (NUM_S),
    .ADDR_W(ADDR_W)
  ) u_decode (
    .m_req   (m_req),
    .m_addr  (m_addr),
    .want_mat(want_mat)
  );

  for (genvar s = 0; s < NUM_S; s++) begin : g_port
    mpsw_port_arb #(
      .NUM_M (NUM_M),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .want       (want_mat[s*NUM_M +: NUM_M]),
      .m_we       (m_we),
      .m_addr     (m_addr),
      .m_wdata    (m_wdata),
      .s_ready    (s_ready[s]),
      .s_req      (s_req[s]),
      .s_we       (s_we[s]),
      .s_addr     (s_addr[s*ADDR_W +: ADDR_W]),
      .s_wdata    (s_wdata[s*DATA_W +: DATA_W]),
      .own        (own_mat[s*NUM_M +: NUM_M]),
      .grant_evt  (grant_evt[s]),
      .release_evt(release_evt[s])
    );
  end

  mpsw_resp_route #(
    .NUM_M (NUM_M),
    .NUM_S (NUM_S),
    .DATA_W(DATA_W)
  ) u_resp (
    .own_mat(own_mat),
    .s_rdata(s_rdata),
    .s_ready(s_ready),
    .s_err  (s_err),
    .m_rdata(m_rdata),
    .m_ready(m_ready),
    .m_err  (m_err)
  );

endmodule

// File: rtl/mpsw_checker.sv
module mpsw_checker
  import mpsw_pkg::*;
#(
  parameter int unsigned NUM_M  = DEF_MASTERS,
  parameter int unsigned NUM_S  = DEF_SLAVES,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_M-1:0]        m_req,
  input logic [NUM_M-1:0]        m_ready,
  input logic [NUM_S-1:0]        s_req,
  input logic [NUM_S-1:0]        s_ready,
  input logic [NUM_S*ADDR_W-1:0] s_addr,
  input logic [NUM_S*NUM_M-1:0]  want_mat,
  input logic [NUM_S*NUM_M-1:0]  own_mat,
  input logic [NUM_S-1:0]        grant_evt
);

  localparam int unsigned SIW = idx_w(NUM_S);

  for (genvar s = 0; s < NUM_S; s++) begin : g_s
    // R1
    addr_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_req[s] |-> (s_addr[s*ADDR_W+ADDR_W-1 -: SIW] == SIW'(s)));

    // R5
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req[s] && !s_ready[s]) |=> (s_req[s] && $stable(own_mat[s*NUM_M +: NUM_M])));

    // R5
    release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req[s] && s_ready[s]) |=> !s_req[s]);

    // R9
    grant_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_evt[s] |=> s_req[s]);

    // R4
    grant_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_req[s]) |-> ((own_mat[s*NUM_M +: NUM_M] & $past(want_mat[s*NUM_M +: NUM_M])) != '0));
  end

  for (genvar m = 0; m < NUM_M; m++) begin : g_m
    logic [NUM_S-1:0] held_by_m;
    for (genvar s = 0; s < NUM_S; s++) begin : g_col
      assign held_by_m[s] = own_mat[s*NUM_M+m];
    end

    // R3
    one_port_per_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(held_by_m) <= 1);

    // R6
    ready_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_ready[m] |-> m_req[m]);
  end

endmodule

bind mport_switch mpsw_checker #(
  .NUM_M (NUM_M),
  .NUM_S (NUM_S),
  .ADDR_W(ADDR_W)
) u_mpsw_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_req    (m_req),
  .m_ready  (m_ready),
  .s_req    (s_req),
  .s_ready  (s_ready),
  .s_addr   (s_addr),
  .want_mat (want_mat),
  .own_mat  (own_mat),
  .grant_evt(grant_evt)
);

// File: tb/mport_switch_bench.sv
module mport_switch_bench;

  localparam int NM = 3;
  localparam int NS = 4;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NM-1:0]    m_req = '0;
  logic [NM-1:0]    m_we = '0;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NM*DW-1:0] m_wdata = '0;
  logic [NM*DW-1:0] m_rdata;
  logic [NM-1:0]    m_ready;
  logic [NM-1:0]    m_err;
  logic [NS-1:0]    s_req;
  logic [NS-1:0]    s_we;
  logic [NS*AW-1:0] s_addr;
  logic [NS*DW-1:0] s_wdata;
  logic [NS*DW-1:0] s_rdata;
  logic [NS-1:0]    s_ready;
  logic [NS-1:0]    s_err;

  mport_switch u_mport_switch (
    .clk(clk), .rst_n(rst_n),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_ready(s_ready), .s_err(s_err)
  );

  // ---------------- bench slave model ----------------
  int unsigned lat = 0;
  int unsigned cnt [NS];
  logic [DW-1:0] wsum [NS];
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      s_ready[s]          = s_req[s] && (cnt[s] == lat);
      s_rdata[s*DW +: DW] = {16'hA5A5, 14'd0, 2'(s), s_addr[s*AW +: AW]};
      s_err[s]            = s_addr[s*AW+3];
    end
  end

  always @(posedge clk or negedge rst_n) begin
    for (int s = 0; s < NS; s++) begin
      if (!rst_n) begin
        cnt[s]  <= 0;
        wsum[s] <= '0;
      end else begin
        if (s_req[s] && !s_ready[s]) cnt[s] <= cnt[s] + 1;
        else                         cnt[s] <= 0;
        if (s_req[s] && s_ready[s] && s_we[s]) wsum[s] <= wsum[s] + s_wdata[s*DW +: DW];
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0;
  int n_err = 0;
  int bench_last [NS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // R1: slave from bits [31:30]
  function automatic int slave_of(input logic [31:0] a);
    return int'(a[31:30]);
  endfunction

  function automatic logic [63:0] exp_rdata(input logic [31:0] a);
    return {16'hA5A5, 14'd0, a[31:30], a};
  endfunction

  function automatic logic [63:0] wdata_of(input int m, input logic [31:0] a);
    return {~a, a ^ 32'(m)};
  endfunction

  typedef struct packed {
    logic [2:0]  act;
    logic [2:0]  we;
    logic [1:0]  lt;
    logic [31:0] a2;
    logic [31:0] a1;
    logic [31:0] a0;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{act:3'b001, we:3'b000, lt:2'd0, a2:32'h0, a1:32'h0, a0:32'h0000_0100},
    '{act:3'b111, we:3'b001, lt:2'd1, a2:32'h0000_0020, a1:32'h8000_0008, a0:32'h4000_0010},
    '{act:3'b111, we:3'b010, lt:2'd0, a2:32'hC000_0030, a1:32'hC000_0018, a0:32'hC000_0000},
    '{act:3'b110, we:3'b100, lt:2'd2, a2:32'hC000_0048, a1:32'hC000_0040, a0:32'h0},
    '{act:3'b011, we:3'b011, lt:2'd0, a2:32'h0, a1:32'h0000_0070, a0:32'h0000_0060},
    '{act:3'b111, we:3'b000, lt:2'd1, a2:32'h0000_0088, a1:32'h0000_0090, a0:32'h0000_0080},
    '{act:3'b101, we:3'b101, lt:2'd0, a2:32'h4000_00A8, a1:32'h0, a0:32'h4000_00A0}
  };

  task automatic run_vector(input vec_t v);
    logic [31:0] a [NM];
    int exp_off [NM];
    int got_cyc [NM];
    int pulses [NM];
    logic [63:0] got_rd [NM];
    logic got_er [NM];
    logic [63:0] exp_ws [NS];
    logic [63:0] ws0 [NS];
    int ctd [NS];
    logic [NM-1:0] drop;
    int base;
    int k;
    int lastm;
    a[0] = v.a0; a[1] = v.a1; a[2] = v.a2;
    // expected order from the requirements (R4, R5)
    for (int s = 0; s < NS; s++) begin
      k = 0; lastm = bench_last[s]; exp_ws[s] = '0;
      for (int step = 1; step <= NM; step++) begin
        int m;
        m = (bench_last[s] + step) % NM;
        if (v.act[m] && slave_of(a[m]) == s) begin
          exp_off[m] = 1 + int'(v.lt) + k * (int'(v.lt) + 2);
          if (v.we[m]) exp_ws[s] = exp_ws[s] + wdata_of(m, a[m]);
          k++; lastm = m;
        end
      end
      ctd[s] = k;
      bench_last[s] = lastm;
    end
    @(negedge clk);
    lat = int'(v.lt);
    for (int m = 0; m < NM; m++) begin
      m_req[m] = v.act[m];
      m_we[m] = v.we[m];
      m_addr[m*AW +: AW] = a[m];
      m_wdata[m*DW +: DW] = wdata_of(m, a[m]);
      got_cyc[m] = -1; pulses[m] = 0; got_rd[m] = '0; got_er[m] = 1'b0;
    end
    for (int s = 0; s < NS; s++) ws0[s] = wsum[s];
    base = cyc;
    drop = '0;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      for (int m = 0; m < NM; m++) if (drop[m]) m_req[m] = 1'b0;
      drop = '0;
      for (int m = 0; m < NM; m++) begin
        if (m_ready[m]) begin
          pulses[m]++;
          if (pulses[m] == 1) begin
            got_cyc[m] = cyc - base;
            got_rd[m] = m_rdata[m*DW +: DW];
            got_er[m] = m_err[m];
            drop[m] = 1'b1;
          end
        end
      end
    end
    for (int m = 0; m < NM; m++) begin
      if (v.act[m]) begin
        chk(pulses[m] == 1, "R6", "ready pulse count", 64'(pulses[m]), 64'd1);
        chk(got_cyc[m] == exp_off[m],
            (ctd[slave_of(a[m])] > 1) ? "R3/R4/R5" : "R2/R9",
            "ready cycle offset", 64'(got_cyc[m]), 64'(exp_off[m]));
        chk(got_rd[m] == exp_rdata(a[m]), "R1/R6", "read data", got_rd[m], exp_rdata(a[m]));
        chk(got_er[m] == a[m][3], "R6", "error bit", 64'(got_er[m]), 64'(a[m][3]));
      end else begin
        chk(pulses[m] == 0, "R6", "idle master ready", 64'(pulses[m]), 64'd0);
      end
    end
    for (int s = 0; s < NS; s++)
      chk((wsum[s] - ws0[s]) == exp_ws[s], "R7", "write data sum",
          wsum[s] - ws0[s], exp_ws[s]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // ---------------- main flow ----------------
  initial begin
    vec_t dv;
    for (int s = 0; s < NS; s++) bench_last[s] = 2;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(m_ready == '0, "R8", "ready in reset", 64'(m_ready), 64'd0);
    chk(s_req == '0, "R8", "slave req in reset", 64'(s_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_req == '0 && m_ready == '0, "R8", "idle after reset",
        64'({s_req, m_ready}), 64'd0);

    for (int i = 0; i < NV; i++) run_vector(VT[i]);

    // directed: reset during an owned transaction (R8)
    @(negedge clk);
    lat = 3;
    m_addr[0 +: AW] = 32'h8000_0000; m_we[0] = 1'b0; m_req[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(s_req[2] == 1'b1, "R9", "port owned before reset", 64'(s_req), 64'h4);
    rst_n = 1'b0;
    m_req = '0;
    @(negedge clk);
    chk(s_req == '0 && m_ready == '0, "R8", "grant dropped by reset",
        64'({s_req, m_ready}), 64'd0);
    rst_n = 1'b1;
    for (int s = 0; s < NS; s++) bench_last[s] = 2;
    // after reset master 0 beats master 1 on the same port (R4, R8)
    dv = '{act:3'b011, we:3'b000, lt:2'd1, a2:32'h0, a1:32'h8000_0110, a0:32'h8000_0100};
    run_vector(dv);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule